// File: doc/BRIEF.md
# Read-Prefetch Snoop Purge Tracker

This block follows the life of one read-prefetch buffer inside a bus bridge and decides when a snooped write makes the prefetched data stale. A prefetch begins with a start event that carries a read command kind and a byte address. The three kinds are a plain read, a line read and a multiple read. From then on the block keeps the base address, the comparison scope that the command kind selects, and a doubleword progress counter inside the aligned 256-byte region. The counter advances on step pulses, and a done input marks the fill as finished.

Every snooped write address is compared against the held base. Plain reads and line reads are compared at the granularity of a 16-byte cache line. Multiple reads are compared over the whole 64-doubleword region, no matter how far the fill has got. On a hit the block raises a one-cycle purge pulse and drops the buffer-valid state in that same cycle. A configuration enable gates all purging. The block copies that enable into an internal armed flag only while no prefetch is valid.

Top module: `rdbuf_snoop_purge`

## Requirements
- R1: After reset, purge, bufValid and bufDone are 0 and progCount is 0.
- R2: A start with startCmd 0 (plain read), 1 (line read) or 2 (multiple read) makes bufValid 1 and bufDone 0 on the next cycle, and loads progCount with startAddr[7:2]. A start with startCmd 3 is ignored and leaves all state unchanged.
- R3: For startCmd 0 or 1, a valid snooped write whose address bits [31:4] equal those of the start address causes a purge. This holds even when the write does not overlap the fetched doublewords, for example a read at 5008h followed by a write to 5000h. A write to a different line, such as 5010h, does not purge.
- R4: For startCmd 2, a snooped write whose bits [31:8] equal those of the start address causes a purge whatever the progress count is, for example progress at doubleword 33 and a write to doubleword 53. A write to another region does not purge.
- R5: purge is asserted in the cycle after the snooped write is sampled. In that same cycle bufValid is 0 and progCount is 0, unless a new start was accepted with the write. Without further hits, purge lasts exactly one cycle.
- R6: A snooped write while bufValid is 0 never produces a purge.
- R7: The purge enable is copied from cfgPurgeEn only in cycles where bufValid is 0. Changing cfgPurgeEn while a prefetch is valid has no effect on that prefetch or on a start that replaces it.
- R8: With the copied enable clear, purge never asserts. bufValid then stays 1 until reset, and a new start only reloads the buffer.
- R9: progStep raises progCount by one, saturating at 63. It is ignored while bufValid is 0 or bufDone is 1.
- R10: progDone with bufValid 1 sets bufDone and keeps bufValid. A finished buffer is still purged by a matching write, and the purge clears bufDone.
- R11: When a start and a snooped write arrive in the same cycle, the write is compared with the old prefetch state and the new prefetch is loaded anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgPurgeEn | input | 1 | Purge enable configuration bit |
| startValid | input | 1 | Prefetch start strobe |
| startCmd | input | 2 | Read kind: 0 plain, 1 line, 2 multiple, 3 reserved |
| startAddr | input | 32 | Byte address of the first prefetched doubleword |
| progStep | input | 1 | One more doubleword prefetched |
| progDone | input | 1 | Prefetch fill finished |
| snoopValid | input | 1 | Snooped write strobe |
| snoopAddr | input | 32 | Byte address of the snooped write |
| purge | output | 1 | One-cycle purge pulse |
| bufValid | output | 1 | Prefetch buffer holds valid data |
| bufDone | output | 1 | Prefetch fill marked finished |
| progCount | output | 6 | Doubleword progress offset inside the 256-byte region |

## Verification
Every output is registered, so each result is due exactly one rising edge after the cycle in which its inputs were sampled. This applies to a start load, a progress step, a done mark and a purge with its clearing of bufValid, bufDone and progCount. The bench changes inputs shortly after an edge, waits for the next rising edge and samples one time unit later, so every check reads the value caused by the stimulus it has just applied. An extra idle cycle after a purge confirms that the pulse has fallen. An extra snoop after an ignored input confirms that the held state is unchanged.

// File: rtl/rdbuf_purge_pkg.sv
package rdbuf_purge_pkg;

  // Read command kinds carried by a prefetch start
  typedef enum logic [1:0] {
    CMD_PLAIN = 2'd0,
    CMD_LINE  = 2'd1,
    CMD_MULTI = 2'd2,
    CMD_RSVD  = 2'd3
  } rd_cmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture new base, scope and offset
    logic clear;  // purge: reset progress counter
    logic step;   // advance progress counter
  } dp_strobe_t;

endpackage

// File: rtl/rdbuf_purge_dp.sv
module rdbuf_purge_dp
  import rdbuf_purge_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DW_LOG2     = 2,
  parameter int LINE_LOG2   = 4,
  parameter int REGION_LOG2 = 8,
  localparam int OFS_W      = REGION_LOG2 - DW_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strobe,
  input  logic [1:0]        startCmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              addrHit,
  output logic [OFS_W-1:0]  progCount
);

  localparam logic [OFS_W-1:0]  CNT_MAX     = '1;
  localparam logic [ADDR_W-1:0] LINE_MASK   = ~((ADDR_W'(1) << LINE_LOG2) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] REGION_MASK = ~((ADDR_W'(1) << REGION_LOG2) - ADDR_W'(1));

  logic [ADDR_W-1:0] baseAddr;
  logic              regionScope;
  logic [OFS_W-1:0]  cntQ;
  logic [ADDR_W-1:0] addrDiff;
  logic              lineMatch;
  logic              regionMatch;

  // Captured prefetch context
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseAddr    <= '0;
      regionScope <= 1'b0;
    end else if (strobe.load) begin
      baseAddr    <= startAddr;
      regionScope <= (rd_cmd_e'(startCmd) == CMD_MULTI);
    end
  end

  // Progress offset inside the region
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (strobe.load) begin
      cntQ <= startAddr[REGION_LOG2-1:DW_LOG2];
    end else if (strobe.clear) begin
      cntQ <= '0;
    end else if (strobe.step && (cntQ != CNT_MAX)) begin
      cntQ <= cntQ + OFS_W'(1);
    end
  end

  // Address comparison against the held prefetch
  always_comb begin
    addrDiff    = snoopAddr ^ baseAddr;
    lineMatch   = ((addrDiff & LINE_MASK) == '0);
    regionMatch = ((addrDiff & REGION_MASK) == '0);
    addrHit     = regionScope ? regionMatch : lineMatch;
  end

  assign progCount = cntQ;

endmodule

// File: rtl/rdbuf_purge_ctrl.sv
module rdbuf_purge_ctrl
  import rdbuf_purge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgPurgeEn,
  input  logic       startValid,
  input  logic [1:0] startCmd,
  input  logic       progStep,
  input  logic       progDone,
  input  logic       snoopValid,
  input  logic       addrHit,
  output dp_strobe_t strobe,
  output logic       purge,
  output logic       bufValid,
  output logic       bufDone,
  output logic       purgeArmed
);

  logic validQ;
  logic doneQ;
  logic purgeQ;
  logic armedQ;
  logic startOk;
  logic snoopHit;

  always_comb begin
    startOk      = startValid && (rd_cmd_e'(startCmd) != CMD_RSVD);
    // compared against the state held before any new load
    snoopHit     = snoopValid && validQ && armedQ && addrHit;
    strobe.load  = startOk;
    strobe.clear = snoopHit;
    strobe.step  = progStep && validQ && !doneQ && !startOk && !snoopHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= 1'b0;
      doneQ  <= 1'b0;
      purgeQ <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      purgeQ <= snoopHit;
      if (!validQ) begin
        armedQ <= cfgPurgeEn;
      end
      if (startOk) begin
        validQ <= 1'b1;
        doneQ  <= 1'b0;
      end else if (snoopHit) begin
        validQ <= 1'b0;
        doneQ  <= 1'b0;
      end else if (progDone && validQ) begin
        doneQ  <= 1'b1;
      end
    end
  end

  assign purge      = purgeQ;
  assign bufValid   = validQ;
  assign bufDone    = doneQ;
  assign purgeArmed = armedQ;

endmodule

// File: rtl/rdbuf_snoop_purge.sv
module rdbuf_snoop_purge
  import rdbuf_purge_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DW_LOG2     = 2,
  parameter int LINE_LOG2   = 4,
  parameter int REGION_LOG2 = 8,
  localparam int OFS_W      = REGION_LOG2 - DW_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgPurgeEn,
  input  logic              startValid,
  input  logic [1:0]        startCmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              progStep,
  input  logic              progDone,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              purge,
  output logic              bufValid,
  output logic              bufDone,
  output logic [OFS_W-1:0]  progCount
);

  dp_strobe_t strobe;
  logic       addrHit;
  logic       purgeArmed;

  rdbuf_purge_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgPurgeEn (cfgPurgeEn),
    .startValid (startValid),
    .startCmd   (startCmd),
    .progStep   (progStep),
    .progDone   (progDone),
    .snoopValid (snoopValid),
    .addrHit    (addrHit),
    .strobe     (strobe),
    .purge      (purge),
    .bufValid   (bufValid),
    .bufDone    (bufDone),
    .purgeArmed (purgeArmed)
  );

  rdbuf_purge_dp #(
    .ADDR_W      (ADDR_W),
    .DW_LOG2     (DW_LOG2),
    .LINE_LOG2   (LINE_LOG2),
    .REGION_LOG2 (REGION_LOG2)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .startCmd  (startCmd),
    .startAddr (startAddr),
    .snoopAddr (snoopAddr),
    .addrHit   (addrHit),
    .progCount (progCount)
  );

endmodule

// File: rtl/rdbuf_purge_chk.sv
module rdbuf_purge_chk #(
  parameter int OFS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startValid,
  input logic [1:0]       startCmd,
  input logic             snoopValid,
  input logic             purge,
  input logic             bufValid,
  input logic             bufDone,
  input logic [OFS_W-1:0] progCount,
  input logic             purgeArmed
);

  assert_purge_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    purge |-> (!bufValid || $past(startValid && (startCmd != 2'd3))));

  assert_purge_needs_prefetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    purge |-> $past(bufValid && snoopValid));

  assert_armed_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bufValid) |-> $stable(purgeArmed));

  assert_disarmed_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(purgeArmed) |-> !purge);

  assert_done_freezes_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bufDone && !startValid) && bufValid) |-> $stable(progCount));

  assert_done_implies_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bufDone |-> bufValid);

endmodule

bind rdbuf_snoop_purge rdbuf_purge_chk #(.OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .startValid (startValid),
  .startCmd   (startCmd),
  .snoopValid (snoopValid),
  .purge      (purge),
  .bufValid   (bufValid),
  .bufDone    (bufDone),
  .progCount  (progCount),
  .purgeArmed (purgeArmed)
);

// File: tb/rdbuf_snoop_purge_bench.sv
module rdbuf_snoop_purge_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgPurgeEn = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  startCmd = 2'd0;
  logic [31:0] startAddr = '0;
  logic        progStep = 1'b0;
  logic        progDone = 1'b0;
  logic        snoopValid = 1'b0;
  logic [31:0] snoopAddr = '0;
  logic        purge;
  logic        bufValid;
  logic        bufDone;
  logic [5:0]  progCount;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  rdbuf_snoop_purge u_rdbuf_snoop_purge (
    .clk(clk), .rst_n(rst_n), .cfgPurgeEn(cfgPurgeEn),
    .startValid(startValid), .startCmd(startCmd), .startAddr(startAddr),
    .progStep(progStep), .progDone(progDone),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .purge(purge), .bufValid(bufValid), .bufDone(bufDone), .progCount(progCount)
  );

  typedef struct packed {
    logic        sv;
    logic [1:0]  cmd;
    logic [31:0] sa;
    logic        wv;
    logic [31:0] wa;
    logic        st;
    logic        dn;
    logic        ep;
    logic        ev;
    logic        ed;
    logic [5:0]  ec;
    logic [7:0]  rq;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd0, 32'h5008, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2,  8'd2},  // R2 plain read
    '{1'b0, 2'd0, 32'h0,    1'b1, 32'h5010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2,  8'd3},  // R3 next line
    '{1'b0, 2'd0, 32'h0,    1'b1, 32'h5000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0,  8'd3},  // R3 same line
    '{1'b0, 2'd0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0,  8'd5},  // R5 pulse falls
    '{1'b0, 2'd0, 32'h0,    1'b1, 32'h5000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0,  8'd6},  // R6 idle write
    '{1'b1, 2'd1, 32'h6004, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd1,  8'd2},  // R2 line read
    '{1'b0, 2'd0, 32'h0,    1'b1, 32'h600C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0,  8'd3},  // R3 line read hit
    '{1'b1, 2'd2, 32'h7080, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd32, 8'd2},  // R2 multiple read
    '{1'b0, 2'd0, 32'h0,    1'b0, 32'h0,    1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd33, 8'd9},  // R9 step
    '{1'b0, 2'd0, 32'h0,    1'b1, 32'h70D4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0,  8'd4},  // R4 ahead of fill
    '{1'b1, 2'd2, 32'h7100, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0,  8'd2},  // R2
    '{1'b0, 2'd0, 32'h0,    1'b1, 32'h7200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0,  8'd4},  // R4 other region
    '{1'b1, 2'd3, 32'h90FC, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0,  8'd2},  // R2 reserved kind ignored
    '{1'b0, 2'd0, 32'h0,    1'b1, 32'h71F0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0,  8'd2},  // R2 old region kept
    '{1'b1, 2'd0, 32'hA000, 1'b1, 32'hA000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0,  8'd11}, // R11 no old state
    '{1'b1, 2'd0, 32'hB00C, 1'b1, 32'hA004, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd3,  8'd11}, // R11 old hit, new loaded
    '{1'b1, 2'd0, 32'hC000, 1'b1, 32'hC000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0,  8'd11}, // R11 new not compared
    '{1'b0, 2'd0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd0,  8'd10}, // R10 done
    '{1'b0, 2'd0, 32'h0,    1'b0, 32'h0,    1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0,  8'd9},  // R9 step after done
    '{1'b0, 2'd0, 32'h0,    1'b1, 32'hC008, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0,  8'd10}  // R10 finished purged
  };

  task automatic drive(input logic sv, input logic [1:0] cmd, input logic [31:0] sa,
                       input logic wv, input logic [31:0] wa, input logic st, input logic dn);
    startValid = sv; startCmd = cmd; startAddr = sa;
    snoopValid = wv; snoopAddr = wa; progStep = st; progDone = dn;
    @(posedge clk);
    #1;
    startValid = 1'b0; snoopValid = 1'b0; progStep = 1'b0; progDone = 1'b0;
  endtask

  task automatic expect_out(input int req, input logic ep, input logic ev,
                            input logic ed, input logic [5:0] ec);
    checks++;
    if (purge !== ep || bufValid !== ev || bufDone !== ed || progCount !== ec) begin
      failures++;
      $display("FAIL R%0d: got purge=%b valid=%b done=%b cnt=%0d, expected purge=%b valid=%b done=%b cnt=%0d",
               req, purge, bufValid, bufDone, progCount, ep, ev, ed, ec);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    expect_out(1, 1'b0, 1'b0, 1'b0, 6'd0); // R1 reset state
    rst_n = 1'b1;
    cfgPurgeEn = 1'b1;
    @(posedge clk);
    #1;
    expect_out(1, 1'b0, 1'b0, 1'b0, 6'd0); // R1 after release

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].sv, VEC[i].cmd, VEC[i].sa, VEC[i].wv, VEC[i].wa, VEC[i].st, VEC[i].dn);
      expect_out(int'(VEC[i].rq), VEC[i].ep, VEC[i].ev, VEC[i].ed, VEC[i].ec);
    end

    // R9 saturation at 63 and step ignored while idle
    drive(1'b1, 2'd2, 32'h70FC, 1'b0, 32'h0, 1'b0, 1'b0);
    expect_out(9, 1'b0, 1'b1, 1'b0, 6'd63);
    drive(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    expect_out(9, 1'b0, 1'b1, 1'b0, 6'd63);
    drive(1'b0, 2'd0, 32'h0, 1'b1, 32'h7000, 1'b0, 1'b0);
    expect_out(4, 1'b1, 1'b0, 1'b0, 6'd0);
    drive(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    expect_out(9, 1'b0, 1'b0, 1'b0, 6'd0); // R9 and R10: ignored while idle

    // R7 enable change while valid has no effect on the running prefetch
    drive(1'b1, 2'd0, 32'hD000, 1'b0, 32'h0, 1'b0, 1'b0);
    cfgPurgeEn = 1'b0;
    drive(1'b0, 2'd0, 32'h0, 1'b1, 32'hD004, 1'b0, 1'b0);
    expect_out(7, 1'b1, 1'b0, 1'b0, 6'd0);

    // R8 disabled: no purge, valid persists
    drive(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(1'b1, 2'd0, 32'hE000, 1'b0, 32'h0, 1'b0, 1'b0);
    expect_out(8, 1'b0, 1'b1, 1'b0, 6'd0);
    drive(1'b0, 2'd0, 32'h0, 1'b1, 32'hE000, 1'b0, 1'b0);
    expect_out(8, 1'b0, 1'b1, 1'b0, 6'd0);
    cfgPurgeEn = 1'b1;
    drive(1'b0, 2'd0, 32'h0, 1'b1, 32'hE008, 1'b0, 1'b0);
    expect_out(7, 1'b0, 1'b1, 1'b0, 6'd0); // R7 late enable ignored
    drive(1'b1, 2'd1, 32'hF008, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(1'b0, 2'd0, 32'h0, 1'b1, 32'hF000, 1'b0, 1'b0);
    expect_out(7, 1'b0, 1'b1, 1'b0, 6'd2); // R7 reload keeps old arming

    // R1 reset clears everything again
    rst_n = 1'b0;
    #1;
    expect_out(1, 1'b0, 1'b0, 1'b0, 6'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule